// File: doc/BRIEF.md
# DAC Master Clock Source Selector

This block picks the master clock that drives a bank of DAC channels. Three candidate clocks are offered: the external master clock pin and two PLL outputs, A and B. In automatic mode the choice, together with the per-channel power-down pattern, follows the digital routing inputs. In override mode a two-bit register field names the clock directly. A flag reports whether the PLL clocks may be used. A sticky fault bit records any automatic-mode request that could not be honoured.

All routing and register inputs are sampled in the register clock domain. A new source is applied by a three-state switch controller that never lets two clock gates open together. `ST_RUN` holds the current source. On a target mismatch it goes to `ST_DROP` and closes every gate enable. `ST_DROP` waits until all gate acknowledges read back low, then opens the new gate and goes to `ST_RAISE`. `ST_RAISE` waits for the new gate's acknowledge, commits the new source and returns to `ST_RUN`. Reset enters `ST_RAISE` with the master clock pin pending.

Each clock has a gate cell. The cell brings the enable into the clock's own domain through a synchroniser, then updates the gate while that clock is low, so the output never carries a shortened pulse.

Top module: `dacclk_select`

## Requirements
- R1: With `man_ovr`=1, `src_field` alone picks the target: 00 and 11 select the master clock pin (`cur_src`=00), 01 selects PLL A (`cur_src`=01), 10 selects PLL B (`cur_src`=10). No fault is raised in this mode.
- R2: After reset the outputs read as follows. `dac_pwrdn`=0 and `req_fault`=0. `pll_ok`=1 while `rx_busy` stays 0. `cur_src` settles to 00.
- R3: With `man_ovr`=0, `rx_to_dac1`=1 and `rx2dac_en`=0, the target is PLL A. `dac_pwrdn` is then 4'b1110: bit 0 is DAC1 and stays powered, and DACs 2 to 4 are powered down.
- R4: With `rx2dac_en`=1, `dac_pwrdn` is 4'b0000. In automatic mode the target then comes from `src_field`, subject to R6.
- R5: `pll_ok` is the inverse of `rx_busy`. Override mode applies the field even when `pll_ok` is 0.
- R6: An automatic-mode request in which `src_field` names a PLL while `rx_busy`=1 falls back to the master clock pin and sets `req_fault`. The forced case of R3 is exempt. `req_fault` stays set until reset.
- R7: `dac_pwrdn`, `pll_ok`, `req_fault` and the switch target all reflect the inputs present at the previous register clock edge, and all update on that same edge.
- R8: `cur_src` never reads 11. It changes only once the new source's gate is open. After a target change it reaches the new target within 40 register clock cycles.
- R9: At most one clock gate is open at any time. Once `cur_src` has settled, `dac_mclk` carries the same number of rising edges as the selected source, within one, over any window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_pin | input | 1 | External master clock candidate |
| pll_a_clk | input | 1 | PLL A clock candidate |
| pll_b_clk | input | 1 | PLL B clock candidate |
| rx_to_dac1 | input | 1 | Routing: DAC1 fed from the S/PDIF receiver |
| rx2dac_en | input | 1 | Receiver-to-DAC mode: DAC1 from receiver, DACs 2 to 4 from primary audio interface |
| rx_busy | input | 1 | S/PDIF receiver in use |
| man_ovr | input | 1 | Manual override of automatic selection |
| src_field | input | 2 | Register clock-source field |
| dac_mclk | output | 1 | Selected, glitch-free DAC master clock |
| dac_pwrdn | output | NUM_DAC | Per-DAC power-down, bit 0 is DAC1 |
| pll_ok | output | 1 | PLL clocks usable |
| req_fault | output | 1 | Sticky invalid-request flag |
| cur_src | output | 2 | Source currently driving `dac_mclk` |

## Verification
The assertions assume the following about the inputs:
- Routing and field inputs are synchronous to `clk`.
- All three candidate clocks keep toggling, including a source that is being switched away from. The handshake needs the old clock to close its own gate.
- `src_field` is meaningful in every encoding.

The stimulus changes inputs only on the falling edge of `clk`. The three candidate clocks are free-running at distinct periods from time zero. Each new configuration is held until `cur_src` has settled, so every handshake completes before the next change.

// File: rtl/dacclk_pkg.sv
package dacclk_pkg;

    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_MCLK = 2'd0,
        SRC_PLLA = 2'd1,
        SRC_PLLB = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DROP  = 2'd1,
        ST_RAISE = 2'd2
    } sw_state_e;

    function automatic src_e field_to_src(input logic [1:0] f);
        src_e s;
        unique case (f)
            2'b01:   s = SRC_PLLA;
            2'b10:   s = SRC_PLLB;
            default: s = SRC_MCLK;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dacclk_route_decode.sv
module dacclk_route_decode
    import dacclk_pkg::*;
#(
    parameter int NUM_DAC = 4
) (
    input  logic               rx_to_dac1,
    input  logic               rx2dac_en,
    input  logic               rx_busy,
    input  logic               man_ovr,
    input  logic [1:0]         src_field,
    output src_e               want_src,
    output logic [NUM_DAC-1:0] want_pd,
    output logic               bad_req,
    output logic               plls_free
);

    localparam logic [NUM_DAC-1:0] PD_DIRECT = {{(NUM_DAC-1){1'b1}}, 1'b0};

    logic direct_rx;
    src_e field_src;

    assign direct_rx = rx_to_dac1 && !rx2dac_en;
    assign field_src = field_to_src(src_field);
    assign plls_free = !rx_busy;
    assign want_pd   = direct_rx ? PD_DIRECT : '0;

    always_comb begin
        want_src = field_src;
        bad_req  = 1'b0;
        if (man_ovr) begin
            want_src = field_src;
        end else if (direct_rx) begin
            want_src = SRC_PLLA;
        end else if (rx_busy && field_src != SRC_MCLK) begin
            want_src = SRC_MCLK;
            bad_req  = 1'b1;
        end
    end

endmodule

// File: rtl/dacclk_gate_cell.sv
module dacclk_gate_cell #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic en,
    output logic gate,
    output logic gclk
);

    logic [SYNC_STAGES-1:0] en_sh;

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) en_sh <= '0;
        else        en_sh <= {en_sh[SYNC_STAGES-2:0], en};
    end

    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) gate <= 1'b0;
        else        gate <= en_sh[SYNC_STAGES-1];
    end

    assign gclk = src_clk & gate;

endmodule

// File: rtl/dacclk_switch_fsm.sv
module dacclk_switch_fsm
    import dacclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  src_e               tgt,
    input  logic [NUM_SRC-1:0] gate_raw,
    output logic [NUM_SRC-1:0] en,
    output src_e               cur
);

    logic [NUM_SRC-1:0] ack_pipe [SYNC_STAGES];
    logic [NUM_SRC-1:0] ack;
    sw_state_e          st_q, st_d;
    src_e               pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) ack_pipe[i] <= '0;
        end else begin
            ack_pipe[0] <= gate_raw;
            for (int i = 1; i < SYNC_STAGES; i++) ack_pipe[i] <= ack_pipe[i-1];
        end
    end

    assign ack = ack_pipe[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RAISE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:   if (tgt != cur)        st_d = ST_DROP;
            ST_DROP:  if (ack == '0)         st_d = ST_RAISE;
            ST_RAISE: if (ack[int'(pend_q)]) st_d = ST_RUN;
            default:                         st_d = ST_RUN;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en     <= NUM_SRC'(1);
            cur    <= SRC_MCLK;
            pend_q <= SRC_MCLK;
        end else begin
            unique case (st_q)
                ST_RUN: begin
                    if (tgt != cur) en <= '0;
                end
                ST_DROP: begin
                    if (ack == '0) begin
                        pend_q         <= tgt;
                        en             <= '0;
                        en[int'(tgt)]  <= 1'b1;
                    end
                end
                ST_RAISE: begin
                    if (ack[int'(pend_q)]) cur <= pend_q;
                end
                default: begin
                    en <= en;
                end
            endcase
        end
    end

endmodule

// File: rtl/dacclk_select.sv
module dacclk_select
    import dacclk_pkg::*;
#(
    parameter int NUM_DAC     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mclk_pin,
    input  logic               pll_a_clk,
    input  logic               pll_b_clk,
    input  logic               rx_to_dac1,
    input  logic               rx2dac_en,
    input  logic               rx_busy,
    input  logic               man_ovr,
    input  logic [1:0]         src_field,
    output logic               dac_mclk,
    output logic [NUM_DAC-1:0] dac_pwrdn,
    output logic               pll_ok,
    output logic               req_fault,
    output logic [1:0]         cur_src
);

    src_e               want_src, tgt_q, cur_e;
    logic [NUM_DAC-1:0] want_pd;
    logic               bad_req, plls_free;
    logic [NUM_SRC-1:0] gate_en, gate_on, gclk;
    logic [NUM_SRC-1:0] src_clks;

    assign src_clks = {pll_b_clk, pll_a_clk, mclk_pin};

    dacclk_route_decode #(.NUM_DAC(NUM_DAC)) u_dec (
        .rx_to_dac1 (rx_to_dac1),
        .rx2dac_en  (rx2dac_en),
        .rx_busy    (rx_busy),
        .man_ovr    (man_ovr),
        .src_field  (src_field),
        .want_src   (want_src),
        .want_pd    (want_pd),
        .bad_req    (bad_req),
        .plls_free  (plls_free)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q     <= SRC_MCLK;
            dac_pwrdn <= '0;
            pll_ok    <= 1'b1;
            req_fault <= 1'b0;
        end else begin
            tgt_q     <= want_src;
            dac_pwrdn <= want_pd;
            pll_ok    <= plls_free;
            req_fault <= req_fault | bad_req;
        end
    end

    dacclk_switch_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt      (tgt_q),
        .gate_raw (gate_on),
        .en       (gate_en),
        .cur      (cur_e)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        dacclk_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
            .src_clk (src_clks[g]),
            .rst_n   (rst_n),
            .en      (gate_en[g]),
            .gate    (gate_on[g]),
            .gclk    (gclk[g])
        );
    end

    assign dac_mclk = |gclk;
    assign cur_src  = cur_e;

endmodule

// File: rtl/dacclk_select_chk.sv
module dacclk_select_chk #(
    parameter int NUM_DAC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_to_dac1,
    input logic               rx2dac_en,
    input logic               rx_busy,
    input logic               man_ovr,
    input logic [1:0]         src_field,
    input logic [NUM_DAC-1:0] dac_pwrdn,
    input logic               pll_ok,
    input logic               req_fault,
    input logic [1:0]         cur_src,
    input logic [2:0]         gate_on
);

    localparam logic [NUM_DAC-1:0] PD_DIRECT = {{(NUM_DAC-1){1'b1}}, 1'b0};

    a_r3_direct_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_to_dac1 && !rx2dac_en) |=> dac_pwrdn == PD_DIRECT);

    a_r4_rx2dac_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        rx2dac_en |=> dac_pwrdn == '0);

    a_r5_pll_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |=> !pll_ok);

    a_r6_fault_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!man_ovr && !(rx_to_dac1 && !rx2dac_en) && rx_busy &&
         (src_field == 2'b01 || src_field == 2'b10)) |=> req_fault);

    a_r6_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        req_fault |=> req_fault);

    a_r8_src_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cur_src != 2'b11);

    a_r8_commit_open: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_src) |-> gate_on[cur_src]);

    a_r9_one_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_on));

endmodule

bind dacclk_select dacclk_select_chk #(.NUM_DAC(NUM_DAC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_to_dac1 (rx_to_dac1),
    .rx2dac_en  (rx2dac_en),
    .rx_busy    (rx_busy),
    .man_ovr    (man_ovr),
    .src_field  (src_field),
    .dac_pwrdn  (dac_pwrdn),
    .pll_ok     (pll_ok),
    .req_fault  (req_fault),
    .cur_src    (cur_src),
    .gate_on    (gate_on)
);

// File: tb/tb_dacclk_select.sv
`timescale 1ns/1ps
module tb_dacclk_select;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       mclk_pin = 1'b0, pll_a_clk = 1'b0, pll_b_clk = 1'b0;
    logic       rx_to_dac1 = 1'b0, rx2dac_en = 1'b0, rx_busy = 1'b0, man_ovr = 1'b0;
    logic [1:0] src_field = 2'b00;
    logic       dac_mclk;
    logic [3:0] dac_pwrdn;
    logic       pll_ok, req_fault;
    logic [1:0] cur_src;

    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk       = ~clk;
    always #13 mclk_pin  = ~mclk_pin;
    always #9  pll_a_clk = ~pll_a_clk;
    always #18 pll_b_clk = ~pll_b_clk;

    dacclk_select dut (
        .clk(clk), .rst_n(rst_n), .mclk_pin(mclk_pin), .pll_a_clk(pll_a_clk),
        .pll_b_clk(pll_b_clk), .rx_to_dac1(rx_to_dac1), .rx2dac_en(rx2dac_en),
        .rx_busy(rx_busy), .man_ovr(man_ovr), .src_field(src_field),
        .dac_mclk(dac_mclk), .dac_pwrdn(dac_pwrdn), .pll_ok(pll_ok),
        .req_fault(req_fault), .cur_src(cur_src)
    );

    // edge counters for R9
    int n_out = 0, n_m = 0, n_a = 0, n_b = 0;
    always @(posedge dac_mclk)  n_out++;
    always @(posedge mclk_pin)  n_m++;
    always @(posedge pll_a_clk) n_a++;
    always @(posedge pll_b_clk) n_b++;

    // behavioural reference model (R7: outputs follow previous edge's inputs)
    int m_tgt = 0, m_pd = 0, m_fault = 0, m_ok = 1;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tgt = 0; m_pd = 0; m_fault = 0; m_ok = 1;
        end else begin
            int fv;
            bit direct;
            direct = rx_to_dac1 && !rx2dac_en;
            fv = (src_field == 2'd1) ? 1 : (src_field == 2'd2) ? 2 : 0;
            if (man_ovr)                m_tgt = fv;
            else if (direct)            m_tgt = 1;
            else if (rx_busy && fv != 0) begin m_tgt = 0; m_fault = 1; end
            else                        m_tgt = fv;
            m_pd = direct ? 14 : 0;
            m_ok = rx_busy ? 0 : 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(dac_pwrdn) == m_pd, "R7 dac_pwrdn", int'(dac_pwrdn), m_pd);
            chk(int'(pll_ok) == m_ok, "R7 pll_ok", int'(pll_ok), m_ok);
            chk(int'(req_fault) == m_fault, "R7 req_fault", int'(req_fault), m_fault);
            chk(cur_src != 2'b11, "R8 cur_src legal", int'(cur_src), 0);
        end
    end

    task automatic report();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic drive(input bit man, input bit r2d1, input bit r2d, input bit busy,
                         input logic [1:0] f);
        @(negedge clk);
        man_ovr = man; rx_to_dac1 = r2d1; rx2dac_en = r2d; rx_busy = busy; src_field = f;
    endtask

    // wait for cur_src to reach exp (R8), then count edges (R9)
    task automatic settle(input int exp, input string tag);
        int c0, c1, d_out, d_src;
        int k;
        k = 0;
        @(negedge clk);
        while (int'(cur_src) != exp && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk(int'(cur_src) == exp, {tag, " R8 settle"}, int'(cur_src), exp);
        repeat (2) @(negedge clk);
        c0 = n_out;
        c1 = (exp == 1) ? n_a : (exp == 2) ? n_b : n_m;
        repeat (40) @(negedge clk);
        d_out = n_out - c0;
        d_src = ((exp == 1) ? n_a : (exp == 2) ? n_b : n_m) - c1;
        chk(d_out - d_src <= 1 && d_src - d_out <= 1, {tag, " R9 edges"}, d_out, d_src);
    endtask

    initial begin
        #4_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dac_pwrdn == 4'b0, "R2 pwrdn reset", int'(dac_pwrdn), 0);
        chk(req_fault == 1'b0, "R2 fault reset", int'(req_fault), 0);
        chk(pll_ok == 1'b1, "R2 pll_ok reset", int'(pll_ok), 1);
        settle(0, "R2 reset source");

        drive(1, 0, 0, 0, 2'b01); settle(1, "R1 field 01");
        drive(1, 0, 0, 0, 2'b10); settle(2, "R1 field 10");
        drive(1, 0, 0, 0, 2'b11); settle(0, "R1 field 11");
        drive(1, 0, 0, 0, 2'b01); settle(1, "R1 field 01 again");
        drive(1, 0, 0, 0, 2'b00); settle(0, "R1 field 00");

        drive(1, 0, 0, 1, 2'b10); settle(2, "R5 override while busy");
        chk(pll_ok == 1'b0, "R5 pll_ok low", int'(pll_ok), 0);
        chk(req_fault == 1'b0, "R5 no fault in override", int'(req_fault), 0);

        drive(0, 1, 0, 1, 2'b00); settle(1, "R3 direct receiver");
        chk(dac_pwrdn == 4'b1110, "R3 pwrdn", int'(dac_pwrdn), 14);

        drive(0, 1, 1, 1, 2'b00); settle(0, "R4 rx2dac");
        chk(dac_pwrdn == 4'b0000, "R4 pwrdn", int'(dac_pwrdn), 0);

        drive(0, 0, 1, 0, 2'b10); settle(2, "R4 field with PLLs free");
        chk(req_fault == 1'b0, "R4 no fault", int'(req_fault), 0);

        drive(0, 0, 0, 1, 2'b01); settle(0, "R6 fallback");
        chk(req_fault == 1'b1, "R6 fault set", int'(req_fault), 1);

        drive(0, 0, 0, 0, 2'b00); settle(0, "R6 clean request");
        chk(req_fault == 1'b1, "R6 fault sticky", int'(req_fault), 1);

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(req_fault == 1'b0, "R2 fault cleared by reset", int'(req_fault), 0);
        settle(0, "R2 after second reset");

        report();
    end

endmodule